// File: doc/BRIEF.md
# ADC Conversion Control Unit

This unit sits between a processor bus and an analog-to-digital converter core. Software programs an 8-bit control word that picks an input channel, chooses single-ended or differential measurement, optionally routes the multiplexer output to external pins, and selects a conversion clock rate. Setting the low bit of that word launches exactly one conversion. The unit powers the converter, issues a one-cycle start, and supplies a divided conversion clock enable. It then waits for the core's done strobe, latches the 10-bit code and drops the busy bit. The result is visible through two read-only registers.

In differential mode each channel code names an ordered pair whose negative input is the code's even/odd neighbour. Neighbouring codes therefore measure the same two inputs with opposite polarity. When pin routing is enabled, the two highest channel codes are given over to that routing. A start request on either of them is refused and flagged.

Top module: `adc_ctrl_unit`

## Requirements
- R1: After reset the control word reads 0x00, and the busy bit, power enable, start strobe, clock enable and error flag are all 0.
- R2: The control word at bus address 0 is laid out as follows: bits 7..4 hold the channel code; bit 3 is the mode (0 single-ended, 1 differential); bit 2 is the pin-routing enable, which also drives `mux_pin_en`; bit 1 is the prescale select; bit 0 is busy/start. The word reads back with this layout.
- R3: A write to address 0 with bit 0 set, made while idle and naming a valid selection, sets busy at that clock edge. It raises `conv_start` for exactly the following cycle only and holds `conv_pwr_en` high while busy. One request yields one conversion.
- R4: Busy clears at the edge that samples `conv_done` while busy, and that edge captures `conv_result`. Address 1 then reads result bits 9..2. Address 2 reads result bits 1..0 in its bits 7..6, with zeros below them.
- R5: In single-ended mode `conv_pos_sel` equals the channel code, `conv_neg_sel` is 0 and `conv_diff` is 0.
- R6: In differential mode `conv_pos_sel` equals the code, `conv_neg_sel` equals the code with bit 0 inverted, and `conv_diff` is 1. This holds for all 16 codes.
- R7: With pin routing enabled, a start on code 14 or 15 is refused. Busy stays 0 and no strobe is issued, the fields are still loaded, and `start_err` (also bit 0 at address 3) becomes 1. The next accepted control write clears it.
- R8: While busy, `conv_clk_en` pulses once every 2 cycles (prescale 0) or once every 4 cycles (prescale 1). The first pulse comes 1 or 3 cycles after the first busy cycle. It is 0 while idle.
- R9: Control writes made while busy change no field, and a write with bit 0 clear does not stop the conversion. The running conversion completes with the selection made at start.
- R10: A `conv_done` strobe while idle leaves the result registers and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 result high, 2 result low, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| conv_pos_sel | output | 4 | Positive input select to converter |
| conv_neg_sel | output | 4 | Negative input select to converter |
| conv_diff | output | 1 | Differential measurement flag |
| conv_pwr_en | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle conversion start |
| conv_clk_en | output | 1 | Divided conversion clock enable |
| conv_done | input | 1 | Conversion complete strobe from core |
| conv_result | input | 10 | Converted code, valid with `conv_done` |
| mux_pin_en | output | 1 | Route multiplexer output to external pins |
| start_err | output | 1 | Last start request was refused |

## Verification
The bench builds the unit with its default parameters: reserved codes 14 and 15, and divide ratios of 2 and 4. With these values every one of the 16 codes can be swept in both modes, and both refused codes are reachable once pin routing is on. Both divider periods fit inside the fixed 12-cycle busy window set by the converter stub. Inside that window the bench checks every cycle of the clock-enable pattern and the one-cycle start strobe. It also attempts control overwrites and a zero busy write during a conversion.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  localparam int CH_W  = 4;
  localparam int RES_W = 10;
  localparam int REG_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            diff;
    logic            mux_out;
    logic            psc_slow;
    logic            busy;
  } ctrl_t;

  // Differential partner: flip the lowest bit of the code.
  function automatic logic [CH_W-1:0] partner_chan(input logic [CH_W-1:0] c);
    return {c[CH_W-1:1], ~c[0]};
  endfunction

  function automatic logic chan_reserved(input logic [CH_W-1:0] c,
                                         input logic [CH_W-1:0] ra,
                                         input logic [CH_W-1:0] rb);
    return (c == ra) || (c == rb);
  endfunction

  function automatic logic [REG_W-1:0] result_hi(input logic [RES_W-1:0] r);
    return r[RES_W-1:RES_W-REG_W];
  endfunction

  function automatic logic [REG_W-1:0] result_lo(input logic [RES_W-1:0] r);
    return {r[RES_W-REG_W-1:0], {(2*REG_W-RES_W){1'b0}}};
  endfunction

endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter logic [CH_W-1:0] RSV_A = 4'd14,
  parameter logic [CH_W-1:0] RSV_B = 4'd15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             conv_done,
  output ctrl_t            ctrl,
  output logic             start_pulse,
  output logic             err,
  output logic             done_accept
);

  ctrl_t req;
  logic  wr_open, refuse, launch;

  assign req         = ctrl_t'(wdata);
  assign wr_open     = wr_ctrl && !ctrl.busy;
  assign refuse      = wr_open && req.busy && req.mux_out &&
                       chan_reserved(req.chan, RSV_A, RSV_B);
  assign launch      = wr_open && req.busy && !refuse;
  assign done_accept = ctrl.busy && conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      start_pulse <= 1'b0;
      err         <= 1'b0;
    end else begin
      start_pulse <= launch;
      if (wr_open) begin
        ctrl.chan     <= req.chan;
        ctrl.diff     <= req.diff;
        ctrl.mux_out  <= req.mux_out;
        ctrl.psc_slow <= req.psc_slow;
        ctrl.busy     <= launch;
        err           <= refuse;
      end else if (done_accept) begin
        ctrl.busy <= 1'b0;
      end
    end
  end

  // R3
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R3
  busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.busy) |-> start_pulse);
  // R9
  fields_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.busy && $past(ctrl.busy)) |->
      ($stable(ctrl.chan) && $stable(ctrl.diff) && $stable(ctrl.mux_out) && $stable(ctrl.psc_slow)));
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !ctrl.busy);
  // R7
  no_reserved_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !(ctrl.mux_out && chan_reserved(ctrl.chan, RSV_A, RSV_B)));

endmodule

// File: rtl/adc_chan_map.sv
module adc_chan_map
  import adc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] chan,
  input  logic            diff,
  output logic [CH_W-1:0] pos_sel,
  output logic [CH_W-1:0] neg_sel,
  output logic            diff_o
);

  always_comb begin
    pos_sel = chan;
    diff_o  = diff;
    neg_sel = diff ? partner_chan(chan) : '0;
  end

  // R6
  pair_neighbour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_o |-> (neg_sel[CH_W-1:1] == pos_sel[CH_W-1:1] && neg_sel[0] != pos_sel[0]));

endmodule

// File: rtl/adc_conv_clkdiv.sv
module adc_conv_clkdiv #(
  parameter int FAST_LOG2 = 1,
  parameter int SLOW_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);

  localparam int CW = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam logic [CW-1:0] MASK_FAST = CW'((1 << FAST_LOG2) - 1);
  localparam logic [CW-1:0] MASK_SLOW = CW'((1 << SLOW_LOG2) - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  assign mask = slow ? MASK_SLOW : MASK_FAST;
  assign tick = run && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R8
  tick_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
  // R8
  tick_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_ctrl_unit.sv
module adc_ctrl_unit
  import adc_ctrl_pkg::*;
#(
  parameter logic [CH_W-1:0] RSV_A     = 4'd14,
  parameter logic [CH_W-1:0] RSV_B     = 4'd15,
  parameter int              FAST_LOG2 = 1,
  parameter int              SLOW_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic [CH_W-1:0]  conv_pos_sel,
  output logic [CH_W-1:0]  conv_neg_sel,
  output logic             conv_diff,
  output logic             conv_pwr_en,
  output logic             conv_start,
  output logic             conv_clk_en,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             mux_pin_en,
  output logic             start_err
);

  ctrl_t            ctrl;
  logic             done_accept;
  logic             wr_ctrl;
  logic [RES_W-1:0] result_q;

  assign wr_ctrl = bus_wr && (bus_addr == 2'd0);

  adc_ctrl_regs #(.RSV_A(RSV_A), .RSV_B(RSV_B)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .conv_done(conv_done), .ctrl(ctrl), .start_pulse(conv_start),
    .err(start_err), .done_accept(done_accept)
  );

  adc_chan_map u_map (
    .clk(clk), .rst_n(rst_n), .chan(ctrl.chan), .diff(ctrl.diff),
    .pos_sel(conv_pos_sel), .neg_sel(conv_neg_sel), .diff_o(conv_diff)
  );

  adc_conv_clkdiv #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl.busy), .slow(ctrl.psc_slow),
    .tick(conv_clk_en)
  );

  assign conv_pwr_en = ctrl.busy;
  assign mux_pin_en  = ctrl.mux_out;

  // Result holds no reset value: undefined until the first conversion.
  always_ff @(posedge clk) begin
    if (done_accept) result_q <= conv_result;
  end

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = ctrl;
      2'd1:    bus_rdata = result_hi(result_q);
      2'd2:    bus_rdata = result_lo(result_q);
      default: bus_rdata = {{(REG_W-1){1'b0}}, start_err};
    endcase
  end

  // R4
  busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_accept |=> !conv_pwr_en);
  // R4
  result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_accept) |-> (result_q == $past(conv_result)));
  // R10
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_pwr_en && !bus_wr) |=> $stable(result_q));

endmodule

// File: tb/adc_ctrl_unit_test.sv
`timescale 1ns/1ps
module adc_ctrl_unit_test;

  localparam int LAT = 10;  // stub latency
  localparam int BUSY_CYC = LAT + 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] conv_pos_sel, conv_neg_sel;
  logic       conv_diff, conv_pwr_en, conv_start, conv_clk_en;
  logic       conv_done;
  logic [9:0] conv_result;
  logic       mux_pin_en, start_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_pos_sel(conv_pos_sel), .conv_neg_sel(conv_neg_sel),
    .conv_diff(conv_diff), .conv_pwr_en(conv_pwr_en), .conv_start(conv_start),
    .conv_clk_en(conv_clk_en), .conv_done(conv_done), .conv_result(conv_result),
    .mux_pin_en(mux_pin_en), .start_err(start_err)
  );

  // Bench-side expectations
  function automatic logic [9:0] stub_code(input logic [3:0] p, input logic [3:0] n, input logic d);
    return (10'(p) * 10'd37) ^ (10'(n) * 10'd11) ^ {d, 9'h0} ^ 10'h155;
  endfunction

  function automatic logic [3:0] exp_neg(input logic [3:0] c, input logic d);
    if (!d) return 4'd0;
    return c[0] ? c - 4'd1 : c + 4'd1;
  endfunction

  // Converter stub
  logic [4:0] scnt;
  logic [9:0] sdata;
  logic       stub_done;
  logic       inj_done = 1'b0;
  logic [9:0] inj_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0; stub_done <= 1'b0; sdata <= '0;
    end else begin
      stub_done <= 1'b0;
      if (conv_start) begin
        scnt  <= 5'(LAT);
        sdata <= stub_code(conv_pos_sel, conv_neg_sel, conv_diff);
      end else if (scnt != 0) begin
        scnt <= scnt - 1'b1;
        if (scnt == 1) stub_done <= 1'b1;
      end
    end
  end

  assign conv_done   = stub_done | inj_done;
  assign conv_result = inj_done ? inj_data : sdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // Full conversion or refused request, checked cycle by cycle.
  task automatic run_conv(input logic [3:0] code, input logic d, input logic m, input logic s);
    logic [7:0] v;
    logic [9:0] er;
    logic [3:0] en;
    bit refused, ok_start, ok_clk, ok_sel, ok_busy, ok_pwr;
    int act_bad;
    refused = m && (code >= 4'd14);
    en = exp_neg(code, d);
    do_write(2'd0, {code, d, m, s, 1'b1});
    if (refused) begin
      chk(!conv_pwr_en && !conv_start, "R7 refused start", {conv_pwr_en, conv_start}, 0);
      chk(start_err, "R7 error flag", start_err, 1);
      rd(2'd3, v);
      chk(v == 8'h01, "R7 status reg", v, 8'h01);
      rd(2'd0, v);
      chk(v == {code, d, m, s, 1'b0}, "R2 readback refused", v, {code, d, m, s, 1'b0});
      @(negedge clk);
      return;
    end
    ok_start = 1; ok_clk = 1; ok_sel = 1; ok_busy = 1; ok_pwr = 1; act_bad = 0;
    for (int k = 1; k <= BUSY_CYC + 1; k++) begin
      bit eb, eclk;
      eb = (k <= BUSY_CYC);
      eclk = eb && ((((k - 1) & (s ? 3 : 1))) == (s ? 3 : 1));
      if (uut.bus_rdata !== uut.bus_rdata) act_bad = 0;
      bus_addr = 2'd0; #1;
      if (bus_rdata[0] !== eb) begin ok_busy = 0; act_bad = k; end
      if (conv_pwr_en !== eb) ok_pwr = 0;
      if (conv_start !== (k == 1)) ok_start = 0;
      if (conv_clk_en !== eclk) ok_clk = 0;
      if (conv_pos_sel !== code || conv_neg_sel !== en || conv_diff !== d) ok_sel = 0;
      @(negedge clk);
    end
    chk(ok_busy, "R3/R4 busy window", act_bad, BUSY_CYC);
    chk(ok_pwr, "R3 power enable", 0, 1);
    chk(ok_start, "R3 start strobe", 0, 1);
    chk(ok_clk, s ? "R8 clk enable div4" : "R8 clk enable div2", 0, 1);
    chk(ok_sel, d ? "R6 diff pair" : "R5 single-ended", {conv_pos_sel, conv_neg_sel}, {code, en});
    er = stub_code(code, en, d);
    rd(2'd1, v);
    chk(v == er[9:2], "R4 result high", v, er[9:2]);
    rd(2'd2, v);
    chk(v == {er[1:0], 6'b0}, "R4 result low", v, {er[1:0], 6'b0});
    chk(!start_err, "R7 error cleared", start_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] hi_s, lo_s;
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v);
    chk(v == 8'h00, "R1 control reset", v, 0);
    chk(!conv_pwr_en && !conv_start && !conv_clk_en && !start_err && !mux_pin_en,
        "R1 outputs reset", {conv_pwr_en, conv_start, conv_clk_en, start_err}, 0);

    // R5/R6 all codes both modes
    for (int c = 0; c < 16; c++) run_conv(4'(c), 1'b0, 1'b0, 1'(c & 1));
    for (int c = 0; c < 16; c++) run_conv(4'(c), 1'b1, 1'b0, 1'(c >> 3));

    // R2 layout, no start
    do_write(2'd0, 8'b1001_1110);
    rd(2'd0, v);
    chk(v == 8'h9E, "R2 field readback", v, 8'h9E);
    chk(mux_pin_en && !conv_pwr_en, "R2 mux pin", mux_pin_en, 1);

    // R7 reserved codes, then clear
    run_conv(4'd14, 1'b0, 1'b1, 1'b0);
    run_conv(4'd15, 1'b1, 1'b1, 1'b1);
    run_conv(4'd13, 1'b0, 1'b1, 1'b0);

    // R9 locking
    do_write(2'd0, {4'd5, 1'b0, 1'b0, 1'b1, 1'b1});
    do_write(2'd0, 8'hA6);
    rd(2'd0, v);
    chk(v == 8'h53, "R9 fields locked", v, 8'h53);
    chk(conv_pwr_en && conv_pos_sel == 4'd5 && !mux_pin_en, "R9 still busy", conv_pwr_en, 1);
    repeat (BUSY_CYC) @(negedge clk);
    rd(2'd0, v);
    chk(v == 8'h52, "R9 completes", v, 8'h52);
    rd(2'd1, v);
    chk(v == stub_code(4'd5, 4'd0, 1'b0) >> 2, "R9 result", v, stub_code(4'd5, 4'd0, 1'b0) >> 2);

    // R10 idle done ignored
    rd(2'd1, hi_s); rd(2'd2, lo_s);
    inj_data = ~stub_code(4'd5, 4'd0, 1'b0); inj_done = 1'b1;
    @(negedge clk); inj_done = 1'b0; @(negedge clk);
    rd(2'd1, v);
    chk(v == hi_s, "R10 result high kept", v, hi_s);
    rd(2'd2, v);
    chk(v == lo_s && !conv_pwr_en, "R10 result low kept", v, lo_s);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      run_conv(r[7:4], r[3], r[2], r[1]);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule